// File: doc/BRIEF.md
# Two-Port Read/Write Memory Built from Single-Write Banks

This block gives two fully independent memory ports, A and B. Each port can read or write one location on every clock cycle. It is built only from storage banks that have one write port and one read port each, and it needs no faster clock. There are four banks. Port A writes banks 0 and 1 at the same address, and port B writes banks 2 and 3. Port A reads banks 0 and 2, and port B reads banks 1 and 3. So each port can see the copy written by either side.

A register holds one bit per address, called the live bit. It records which port wrote that location most recently. On a read, the live bit of the addressed location is captured in the same cycle as the bank data. One cycle later it steers an output multiplexer that selects the copy holding current data. Depth and data width are parameters.

Top module: `banked_tdp_ram`

## Requirements
- R1: Data written through port A at an address is returned by a later port A read of that address, when nothing has written the address in between.
- R2: Data written through port B at an address is returned by a later port B read of that address, when nothing has written the address in between.
- R3: Data written through one port is returned by a later read of the same address through the other port. This holds at every address, including address 0 and the highest address.
- R4: A read started with a port's enable high in cycle t shows on that port's read data after the clock edge that ends cycle t. While the enable is low, the port's read data holds its previous value.
- R5: In the same cycle, one port can write an address while the other port reads or writes a different address. Both operations complete correctly.
- R6: When both ports write the same address in the same cycle, port B's data wins. Later reads from either port return B's value.
- R7: A read of an address that is being written in the same cycle returns the data held before that write. This applies whether the write comes from the same port or from the other port.
- R8: While the reset input is low, and after reset is released, both read-data outputs are 0 until a read completes. The live bit of every address starts at 0, which means "port A wrote last".
- R9: A port A write to an address that port B wrote earlier clears that address's live bit to 0. After that, both ports return A's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| a_en | input | 1 | Port A enable: this cycle performs a read, and also a write if a_we is high |
| a_we | input | 1 | Port A write enable, only used while a_en is high |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, one cycle after the enable |
| b_en | input | 1 | Port B enable: this cycle performs a read, and also a write if b_we is high |
| b_we | input | 1 | Port B write enable, only used while b_en is high |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, one cycle after the enable |

## Verification
Several properties are checked on every cycle by the assertions:
- after a single write or a same-address collision, the live bit takes the correct value;
- read data holds while a port is idle;
- a write from one port followed by a read from the other port in the next cycle returns the written word.

Some behaviours can only be shown by the bench's scenarios:
- the old-data result when a read and a write hit the same address in one cycle;
- B winning a collision, as seen at both outputs;
- a later A write taking over an address that B wrote;
- accesses at the address extremes.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  // Which port wrote a location most recently
  typedef enum logic {
    LIVE_A = 1'b0,
    LIVE_B = 1'b1
  } live_e;

  localparam int unsigned NUM_BANKS = 4;
endpackage

// File: rtl/tdp_rst_sync.sv
module tdp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/tdp_bank.sv
module tdp_bank #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_d;

  // Storage array: one write port, no reset
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Read register samples the array before this edge's write lands
  always_comb begin
    rd_d = rd_q;
    if (re) rd_d = store[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;

  // R4: an idle read port keeps its output
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));
endmodule

// File: rtl/tdp_live_table.sv
module tdp_live_table
  import tdp_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_rd,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_rd,
  output live_e             a_live,
  output live_e             b_live
);
  live_e live_q [DEPTH];
  live_e live_d [DEPTH];
  live_e a_sel_q, a_sel_d;
  live_e b_sel_q, b_sel_d;

  // Next state per entry; B is applied last so it wins a collision
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_comb begin
      live_d[g] = live_q[g];
      if (a_wr && (a_addr == ADDR_W'(g))) live_d[g] = LIVE_A;
      if (b_wr && (b_addr == ADDR_W'(g))) live_d[g] = LIVE_B;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q[g] <= LIVE_A;
      else        live_q[g] <= live_d[g];
    end
  end

  // Selector captured with the same latency as the bank read
  always_comb begin
    a_sel_d = a_sel_q;
    b_sel_d = b_sel_q;
    if (a_rd) a_sel_d = live_q[a_addr];
    if (b_rd) b_sel_d = live_q[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sel_q <= LIVE_A;
      b_sel_q <= LIVE_A;
    end else begin
      a_sel_q <= a_sel_d;
      b_sel_q <= b_sel_d;
    end
  end

  assign a_live = a_sel_q;
  assign b_live = b_sel_q;

  // R6: collision leaves the entry marked for port B
  p_collide_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && b_wr && a_addr == b_addr) |=> live_q[$past(b_addr)] == LIVE_B);

  // R9: a lone A write marks the entry for port A
  p_a_claims_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && !(b_wr && b_addr == a_addr)) |=> live_q[$past(a_addr)] == LIVE_A);

  // R2: a B write marks the entry for port B
  p_b_claims_r2: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr |=> live_q[$past(b_addr)] == LIVE_B);
endmodule

// File: rtl/banked_tdp_ram.sv
module banked_tdp_ram
  import tdp_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic rst_ns;
  logic a_wr, b_wr;
  logic [DATA_W-1:0] bank_q [NUM_BANKS];
  live_e a_live, b_live;

  assign a_wr = a_en && a_we;
  assign b_wr = b_en && b_we;

  tdp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  // Banks 0,1 written by A, banks 2,3 by B; even banks read by A, odd by B
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam bit WR_FROM_B = (g >= 2);
    localparam bit RD_TO_B   = (g % 2 == 1);

    tdp_bank #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_ns),
      .we    (WR_FROM_B ? b_wr    : a_wr),
      .waddr (WR_FROM_B ? b_addr  : a_addr),
      .wdata (WR_FROM_B ? b_wdata : a_wdata),
      .re    (RD_TO_B   ? b_en    : a_en),
      .raddr (RD_TO_B   ? b_addr  : a_addr),
      .rdata (bank_q[g])
    );
  end

  tdp_live_table #(
    .DEPTH (DEPTH)
  ) u_live (
    .clk    (clk),
    .rst_n  (rst_ns),
    .a_wr   (a_wr),
    .a_addr (a_addr),
    .a_rd   (a_en),
    .b_wr   (b_wr),
    .b_addr (b_addr),
    .b_rd   (b_en),
    .a_live (a_live),
    .b_live (b_live)
  );

  // Output selection from registered bank data and registered live bit
  always_comb begin
    a_rdata = (a_live == LIVE_B) ? bank_q[2] : bank_q[0];
    b_rdata = (b_live == LIVE_B) ? bank_q[3] : bank_q[1];
  end

  // Cycles since reset, so that the $past depth-2 checks start clean
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R3: A write, then a B read of that address in the next cycle
  p_a_to_b_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (age_q == 2'd3 && b_en && $past(a_wr) && b_addr == $past(a_addr)
     && !$past(b_wr && b_addr == a_addr))
    |=> b_rdata == $past(a_wdata, 2));

  // R3: B write, then an A read of that address in the next cycle
  p_b_to_a_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (age_q == 2'd3 && a_en && $past(b_wr) && a_addr == $past(b_addr))
    |=> a_rdata == $past(b_wdata, 2));

  // R4: an idle port's output holds
  p_port_hold_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    !a_en |=> $stable(a_rdata));
endmodule

// File: tb/banked_tdp_ram_bench.sv
module banked_tdp_ram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = $clog2(DEPTH);

  typedef struct packed {
    logic              a_en;
    logic              a_we;
    logic [ADDR_W-1:0] a_addr;
    logic [DATA_W-1:0] a_wd;
    logic              b_en;
    logic              b_we;
    logic [ADDR_W-1:0] b_addr;
    logic [DATA_W-1:0] b_wd;
    logic              chk_a;
    logic [DATA_W-1:0] exp_a;
    logic              chk_b;
    logic [DATA_W-1:0] exp_b;
    logic [3:0]        req;   // requirement number for messages
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1,1,4'd3, 8'h11, 1,1,4'd5, 8'h22, 0,8'h00, 0,8'h00, 4'd5}, // R5 writes
    '{1,0,4'd5, 8'h00, 1,0,4'd3, 8'h00, 1,8'h22, 1,8'h11, 4'd3}, // R3 cross
    '{1,0,4'd3, 8'h00, 1,0,4'd5, 8'h00, 1,8'h11, 1,8'h22, 4'd1}, // R1/R2
    '{1,1,4'd7, 8'h33, 1,1,4'd7, 8'h44, 0,8'h00, 0,8'h00, 4'd6}, // collision
    '{1,0,4'd7, 8'h00, 1,0,4'd7, 8'h00, 1,8'h44, 1,8'h44, 4'd6}, // R6 B wins
    '{1,1,4'd7, 8'h55, 1,0,4'd7, 8'h00, 1,8'h44, 1,8'h44, 4'd7}, // R7 old data
    '{1,0,4'd7, 8'h00, 1,0,4'd7, 8'h00, 1,8'h55, 1,8'h55, 4'd9}, // R9
    '{1,1,4'd9, 8'h66, 1,0,4'd3, 8'h00, 0,8'h00, 1,8'h11, 4'd5}, // R5
    '{1,0,4'd9, 8'h00, 1,1,4'd3, 8'h77, 1,8'h66, 1,8'h11, 4'd7}, // R5/R7
    '{1,0,4'd3, 8'h00, 0,0,4'd0, 8'h00, 1,8'h77, 1,8'h11, 4'd4}, // R3, B holds
    '{0,0,4'd0, 8'h00, 0,0,4'd0, 8'h00, 1,8'h77, 1,8'h11, 4'd4}, // R4 hold
    '{1,1,4'd0, 8'hAA, 1,1,4'd15,8'hBB, 0,8'h00, 0,8'h00, 4'd3}, // edges
    '{1,0,4'd15,8'h00, 1,0,4'd0, 8'h00, 1,8'hBB, 1,8'hAA, 4'd3}  // R3 edges
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              a_en, a_we, b_en, b_we;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [DATA_W-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_tdp_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_banked_tdp_ram (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs cleared during reset
    check("R8", "a_rdata in reset", a_rdata, '0);
    check("R8", "b_rdata in reset", b_rdata, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", "a_rdata after release", a_rdata, '0);
    check("R8", "b_rdata after release", b_rdata, '0);

    for (int i = 0; i < NV; i++) begin
      a_en = VECS[i].a_en; a_we = VECS[i].a_we;
      a_addr = VECS[i].a_addr; a_wdata = VECS[i].a_wd;
      b_en = VECS[i].b_en; b_we = VECS[i].b_we;
      b_addr = VECS[i].b_addr; b_wdata = VECS[i].b_wd;
      @(negedge clk);
      if (VECS[i].chk_a)
        check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d a_rdata", i),
              a_rdata, VECS[i].exp_a);
      if (VECS[i].chk_b)
        check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d b_rdata", i),
              b_rdata, VECS[i].exp_b);
    end
    idle();

    // R7: the same port writes and reads an address in one cycle and gets the old word
    a_en = 1; a_we = 1; a_addr = 4'd15; a_wdata = 8'hC3;
    @(negedge clk);
    check("R7", "A self read-before-write", a_rdata, 8'hBB);
    a_we = 0;
    @(negedge clk);
    check("R9", "A takes over address 15", a_rdata, 8'hC3);
    idle();
    b_en = 1; b_addr = 4'd15;
    @(negedge clk);
    check("R9", "B sees A data at 15", b_rdata, 8'hC3);
    idle();

    // R8: a reset in the middle of operation clears the outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R8", "a_rdata mid reset", a_rdata, '0);
    check("R8", "b_rdata mid reset", b_rdata, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule